// File: doc/BRIEF.md
# Time-Aware Gate Control Scheduler

This block drives the eight per-traffic-class transmission gates of one egress port from a programmable list of timed gate states. It follows a time-of-day input given as seconds and nanoseconds. Software fills an administrative copy of the schedule: a start time, a cycle length, a cycle-time extension, a list length and up to 63 entries. Each entry pairs an 8-bit open mask with a hold time in nanoseconds. Software then raises a change request. The block works out when the new schedule is to begin and swaps the administrative copy into operation at that instant. It then steps through the list once per cycle.

A start time that already lies in the past is moved forward to the first cycle boundary that comes strictly after the current time. While a change is waiting to take effect, the administrative copy is locked against writes. The request bit doubles as the status that software polls. When no schedule is running, every gate is held open. Time is assumed to advance by `NS_PER_CLK` nanoseconds per clock.

Top module: `tsn_gate_sched`

## Requirements
- R1: Out of reset and whenever no schedule is running, `gate_open` is 8'hFF, `pending` is 0 and `cfg_err` is 0.
- R2: A list-length write (address 4) is accepted for values 1 to 63. Any other value is refused: `cfg_err` rises in the following cycle and the previous length is kept.
- R3: A cycle-time write (address 5) is accepted for 1 to 1,000,000,000 ns. An extension write (address 6) is accepted below 1,000,000,000 ns, and so is a start-nanoseconds write (address 1). An entry-select write (address 7: bits 5:0 index, bits 15:8 mask) is accepted for indices below 63. Any other write to these addresses, or any write to an unused address, is refused with `cfg_err`.
- R4: Writing control (address 0) with bits 1:0 = 2'b11 while nothing is pending sets `pending` in the next cycle. `pending` clears by itself in the cycle in which the new schedule starts.
- R5: While `pending` is 1, every write to addresses 1 to 15 and every further change request is refused with `cfg_err`, and the administrative configuration is left unchanged.
- R6: With a start time in the future, the gates stay as they were until time reaches the start. In the clock at which time equals the start, `gate_open` shows the mask of entry 0.
- R7: With a start time earlier than the time of the request, the schedule begins at start + cycle × (floor((now − start)/cycle) + 1). This keeps the gate phase equal to (t − start) mod cycle.
- R8: Inside each cycle the entries follow one another. Each one holds for its interval. After the last entry its mask is held until the cycle boundary, and every cycle restarts at entry 0.
- R9: When the entries add up to more than the cycle, the list is cut short at the cycle boundary and entry 0 starts again there.
- R10: If a pending schedule's start lies less than the extension after a boundary of the running cycle, no new cycle begins at that boundary. The last mask is held until the new schedule starts.
- R11: Writing control with bit 0 = 0 stops the schedule and cancels any pending change. In the next cycle `gate_open` is 8'hFF and `pending` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tod_sec | input | SEC_W | Current time, whole seconds |
| tod_ns | input | 30 | Current time, nanoseconds within the second |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| gate_open | output | GATES | Open state of each traffic-class gate |
| pending | output | 1 | Change request outstanding; administrative copy locked |
| cfg_err | output | 1 | One-cycle pulse after a refused write |

## Verification
The bench goes after a start time in the past. A design that rolled to a boundary at or before the present would start at once with the wrong phase, and every later gate sample would be off. A list that is longer than its cycle catches a design that lets the last entry run on past the boundary. A new start placed just after a boundary, inside the extension, catches a design that opens a fresh cycle instead of holding the last mask. Writes made while a change is pending, and illegal lengths, must leave the installed schedule exactly as loaded, so a design that let them through shows the wrong masks once the schedule is running.

// File: rtl/tsn_gate_sched.sv
module tsn_gate_sched #(
  parameter int GATES      = 8,
  parameter int LIST_MAX   = 63,
  parameter int SEC_W      = 48,
  parameter int NS_PER_CLK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] tod_sec,
  input  logic [29:0]      tod_ns,
  input  logic             cfg_we,
  input  logic [3:0]       cfg_addr,
  input  logic [31:0]      cfg_wdata,
  output logic [GATES-1:0] gate_open,
  output logic             pending,
  output logic             cfg_err
);
  localparam int IDX_W = $clog2(LIST_MAX + 1);
  localparam int DEPTH = 2 ** (IDX_W + 1);
  localparam int TW    = SEC_W + 30;
  localparam logic [31:0] NS_SEC = 32'd1000000000;
  localparam logic [31:0] STEP   = NS_PER_CLK;
  localparam logic [31:0] LMAX   = LIST_MAX;
  localparam logic [3:0] A_CTRL = 4'd0, A_BNS = 4'd1, A_SLO = 4'd2, A_SHI = 4'd3,
                         A_LEN = 4'd4, A_CYC = 4'd5, A_EXT = 4'd6, A_SEL = 4'd7, A_IV = 4'd8;

  logic [GATES-1:0] gmem [DEPTH];
  logic [31:0]      imem [DEPTH];

  logic             calc_q, past_q, run_q, hold_q, bank_q, pend_q, err_q;
  logic [29:0]      a_ns, st_ns;
  logic [SEC_W-1:0] a_sec, st_sec;
  logic [IDX_W-1:0] a_len, op_len, idx, sel_idx;
  logic [GATES-1:0] sel_gate, gate_q;
  logic [31:0]      a_cyc, a_ext, op_cyc, ent_left, cyc_left;

  wire [TW-1:0] now_t  = {tod_sec, tod_ns};
  wire [TW-1:0] st_t   = {st_sec, st_ns};
  wire [TW-1:0] base_t = {a_sec, a_ns};

  wire [30:0] roll_ns = {1'b0, st_ns} + a_cyc[30:0];
  wire        roll_c  = roll_ns >= NS_SEC[30:0];
  wire [30:0] roll_nw = roll_c ? roll_ns - NS_SEC[30:0] : roll_ns;
  wire [30:0] ext_ns  = {1'b0, tod_ns} + a_ext[30:0];
  wire        ext_c   = ext_ns >= NS_SEC[30:0];
  wire [30:0] ext_nw  = ext_c ? ext_ns - NS_SEC[30:0] : ext_ns;
  wire [TW-1:0] ext_t = {tod_sec + SEC_W'(ext_c), ext_nw[29:0]};

  wire armed   = pend_q && !calc_q;
  wire go      = armed && (now_t >= st_t);
  wire stretch = armed && (st_t < ext_t);

  wire [IDX_W-1:0] nxt  = idx + 1'b1;
  wire             more = ({1'b0, idx} + 1'b1) < {1'b0, op_len};
  wire [IDX_W:0]   rd_nxt = {bank_q, nxt};
  wire [IDX_W:0]   rd_op0 = {bank_q, {IDX_W{1'b0}}};
  wire [IDX_W:0]   rd_ad0 = {~bank_q, {IDX_W{1'b0}}};

  logic refuse;
  always_comb begin
    refuse = 1'b0;
    if (cfg_addr == A_CTRL) refuse = pend_q && cfg_wdata[0] && cfg_wdata[1];
    else if (pend_q) refuse = 1'b1;
    else
      case (cfg_addr)
        A_BNS:        refuse = cfg_wdata >= NS_SEC;
        A_LEN:        refuse = cfg_wdata == 32'd0 || cfg_wdata > LMAX;
        A_CYC:        refuse = cfg_wdata == 32'd0 || cfg_wdata > NS_SEC;
        A_EXT:        refuse = cfg_wdata >= NS_SEC;
        A_SEL:        refuse = {26'd0, cfg_wdata[5:0]} >= LMAX;
        A_SLO, A_SHI, A_IV: refuse = 1'b0;
        default:      refuse = 1'b1;
      endcase
  end
  wire take = cfg_we && !refuse;

  always_ff @(posedge clk)
    if (take && cfg_addr == A_IV) begin
      gmem[{~bank_q, sel_idx}] <= sel_gate;
      imem[{~bank_q, sel_idx}] <= cfg_wdata;
    end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {calc_q, past_q, run_q, hold_q, bank_q, pend_q, err_q} <= '0;
      {a_ns, st_ns, a_sec, st_sec} <= '0;
      {a_len, op_len, idx, sel_idx, sel_gate, gate_q} <= '0;
      {a_cyc, a_ext, op_cyc, ent_left, cyc_left} <= '0;
    end else begin
      err_q <= cfg_we && refuse;
      if (calc_q) begin
        if (past_q && st_t <= now_t) begin
          st_sec <= st_sec + SEC_W'(roll_c);
          st_ns  <= roll_nw[29:0];
        end else calc_q <= 1'b0;
      end
      if (go) begin
        {run_q, hold_q, pend_q} <= 3'b100;
        bank_q   <= ~bank_q;
        op_len   <= a_len;
        op_cyc   <= a_cyc;
        cyc_left <= a_cyc;
        idx      <= '0;
        gate_q   <= gmem[rd_ad0];
        ent_left <= imem[rd_ad0];
      end else if (run_q && !hold_q) begin
        if (cyc_left <= STEP) begin
          if (stretch) hold_q <= 1'b1;
          else begin
            cyc_left <= op_cyc;
            idx      <= '0;
            gate_q   <= gmem[rd_op0];
            ent_left <= imem[rd_op0];
          end
        end else begin
          cyc_left <= cyc_left - STEP;
          if (ent_left > STEP) ent_left <= ent_left - STEP;
          else if (more) begin
            idx      <= nxt;
            gate_q   <= gmem[rd_nxt];
            ent_left <= imem[rd_nxt];
          end
        end
      end
      if (take)
        case (cfg_addr)
          A_CTRL:
            if (!cfg_wdata[0]) {calc_q, run_q, hold_q, pend_q} <= '0;
            else if (cfg_wdata[1]) begin
              pend_q <= 1'b1;
              calc_q <= 1'b1;
              past_q <= base_t < now_t;
              st_sec <= a_sec;
              st_ns  <= a_ns;
            end
          A_BNS: a_ns <= cfg_wdata[29:0];
          A_SLO: a_sec[31:0] <= cfg_wdata;
          A_SHI: a_sec[SEC_W-1:32] <= cfg_wdata[SEC_W-33:0];
          A_LEN: a_len <= cfg_wdata[IDX_W-1:0];
          A_CYC: a_cyc <= cfg_wdata;
          A_EXT: a_ext <= cfg_wdata;
          A_SEL: begin
            sel_idx  <= cfg_wdata[IDX_W-1:0];
            sel_gate <= cfg_wdata[8 +: GATES];
          end
          default: ;
        endcase
    end
  end

  assign gate_open = run_q ? gate_q : '1;
  assign pending   = pend_q;
  assign cfg_err   = err_q;
endmodule

// File: rtl/tsn_gate_sched_chk.sv
module tsn_gate_sched_chk #(
  parameter int GATES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [3:0]       cfg_addr,
  input logic [31:0]      cfg_wdata,
  input logic [GATES-1:0] gate_open,
  input logic             pending,
  input logic             cfg_err
);
  // R11
  stop_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == 4'd0 && !cfg_wdata[0] |=> gate_open == '1 && !pending);

  // R4
  req_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == 4'd0 && cfg_wdata[1:0] == 2'b11 && !pending |=> pending);

  // R5
  locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr != 4'd0 && pending |=> cfg_err);

  // R2
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == 4'd4 && (cfg_wdata == 32'd0 || cfg_wdata > 32'd63) |=> cfg_err);

  // R3
  cyc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_addr == 4'd5 && (cfg_wdata == 32'd0 || cfg_wdata > 32'd1000000000) |=> cfg_err);

  // R1
  quiet_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> !cfg_err);
endmodule

bind tsn_gate_sched tsn_gate_sched_chk #(.GATES(GATES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
  .gate_open(gate_open), .pending(pending), .cfg_err(cfg_err)
);

// File: tb/tsn_gate_sched_tb.sv
`timescale 1ns/1ps
module tsn_gate_sched_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] data = '0;
  logic [7:0]  gate_open;
  logic        pending, cfg_err;
  int          tod_i = 0;
  logic        tod_run = 1'b0;
  int          checks = 0, errors = 0;

  always #2 clk = ~clk;

  tsn_gate_sched u_dut (
    .clk(clk), .rst_n(rst_n), .tod_sec(48'd0), .tod_ns(30'(tod_i)),
    .cfg_we(we), .cfg_addr(addr), .cfg_wdata(data),
    .gate_open(gate_open), .pending(pending), .cfg_err(cfg_err)
  );

  initial forever begin
    @(negedge clk);
    if (tod_run) tod_i += 4;
  end

  localparam int NV = 22;
  localparam logic [36:0] VEC [NV] = '{
    {4'd4, 32'd3, 1'b0},          {4'd4, 32'd64, 1'b1},         {4'd4, 32'd0, 1'b1},
    {4'd5, 32'd1000000000, 1'b0}, {4'd5, 32'd1000000001, 1'b1}, {4'd5, 32'd0, 1'b1},
    {4'd5, 32'd400, 1'b0},        {4'd6, 32'd999999999, 1'b0},  {4'd6, 32'd1000000000, 1'b1},
    {4'd6, 32'd0, 1'b0},          {4'd7, 32'h0100, 1'b0},       {4'd8, 32'd100, 1'b0},
    {4'd7, 32'h0201, 1'b0},       {4'd8, 32'd100, 1'b0},        {4'd7, 32'h0402, 1'b0},
    {4'd8, 32'd100, 1'b0},        {4'd7, 32'h003F, 1'b1},       {4'd1, 32'd1000000000, 1'b1},
    {4'd1, 32'd2000, 1'b0},       {4'd2, 32'd0, 1'b0},          {4'd3, 32'd0, 1'b0},
    {4'd9, 32'd0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at t=%0d: got %0h expected %0h", req, tod_i, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, output logic e);
    @(posedge clk);
    #1 we = 1'b1; addr = a; data = d;
    @(posedge clk);
    #1 we = 1'b0;
    e = cfg_err;
  endtask

  function automatic logic [7:0] sched(input int pos, input int n,
      input logic [7:0] g0, input logic [7:0] g1, input logic [7:0] g2,
      input int i0, input int i1);
    if (pos < i0 || n == 1) return g0;
    if (pos < i0 + i1 || n == 2) return g1;
    return g2;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic e;
    int t, tq, m, b;
    repeat (5) tick();
    rst_n = 1'b1;
    tick();
    check("R1 reset gates", 32'(gate_open), 32'hFF);
    check("R1 reset pending", 32'(pending), 0);
    check("R1 reset err", 32'(cfg_err), 0);
    tod_run = 1'b1;

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][36:33], VEC[i][32:1], e);
      check("R2/R3 vector", 32'(e), 32'(VEC[i][0]));
    end
    check("R1 idle gates", 32'(gate_open), 32'hFF);

    // future start at 2000, three entries in a 400 ns cycle
    wr(4'd0, 32'd3, e);
    check("R4 request accepted", 32'(e), 0);
    check("R4 pending set", 32'(pending), 1);
    wr(4'd7, 32'hAA00, e);
    check("R5 locked entry write", 32'(e), 1);
    wr(4'd0, 32'd3, e);
    check("R5 second request", 32'(e), 1);
    while (tod_i < 3200) begin
      tick();
      t = tod_i;
      if (t < 2000) check("R6 before start", 32'(gate_open), 32'hFF);
      else check("R8 R6 schedule", 32'(gate_open), 32'(sched((t - 2000) % 400, 3, 8'h01, 8'h02, 8'h04, 100, 100)));
      if (t == 2000) check("R4 self clear", 32'(pending), 0);
    end

    // past start, list longer than cycle
    wr(4'd4, 32'd2, e);
    wr(4'd5, 32'd240, e);
    wr(4'd7, 32'h1000, e);
    wr(4'd8, 32'd160, e);
    wr(4'd7, 32'h2001, e);
    wr(4'd8, 32'd160, e);
    wr(4'd1, 32'd0, e);
    tq = tod_i;
    wr(4'd0, 32'd3, e);
    while (tod_i < tq + 400) tick();
    check("R4 cleared after past start", 32'(pending), 0);
    while (tod_i < tq + 1120) begin
      tick();
      t = tod_i;
      check("R7 R9 rolled truncated", 32'(gate_open), 32'(sched(t % 240, 2, 8'h10, 8'h20, 8'h00, 160, 160)));
    end

    // new start 100 ns after a boundary, extension 200 ns
    wr(4'd4, 32'd1, e);
    wr(4'd5, 32'd800, e);
    wr(4'd6, 32'd200, e);
    wr(4'd7, 32'h4000, e);
    wr(4'd8, 32'd1000, e);
    m = tod_i / 240 + 3;
    b = 240 * m + 100;
    wr(4'd1, 32'(b), e);
    wr(4'd0, 32'd3, e);
    while (tod_i < b + 1600) begin
      tick();
      t = tod_i;
      if (t < b - 100) check("R9 old schedule", 32'(gate_open), 32'(sched(t % 240, 2, 8'h10, 8'h20, 8'h00, 160, 160)));
      else if (t < b) check("R10 stretched", 32'(gate_open), 32'h20);
      else check("R10 new schedule", 32'(gate_open), 32'h40);
    end

    // stop while a change is pending
    wr(4'd1, 32'(tod_i + 5000), e);
    wr(4'd0, 32'd3, e);
    check("R4 pending again", 32'(pending), 1);
    wr(4'd0, 32'd0, e);
    check("R11 pending cancelled", 32'(pending), 0);
    check("R11 gates open", 32'(gate_open), 32'hFF);
    repeat (20) begin
      tick();
      check("R11 stays open", 32'(gate_open), 32'hFF);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule